// File: doc/BRIEF.md
# Indexed Clock-Synthesizer Register Port

This block gives a host a narrow window onto a small bank of eight-bit clock-synthesizer registers. The host sees a single 32-bit control word split into byte lanes. The host first writes a byte to the index lane. That byte holds the register number and a write flag. The host then moves data through the data lane. A data-lane write updates the selected register only if the latched flag permits it. A read of the data lane returns the selected register. The lowest lane holds a two-bit pixel-clock select. A one-shot reload request also travels on that lane.

Every register of the bank is also presented in parallel on a flat output bus, so downstream clock logic can use the dividers directly without going through the host. A data-lane write in the same cycle as an index-lane write uses the index and flag that were latched before that cycle.

Top module: `clkreg_port`

## Requirements
- R1: After reset, all bank entries, the latched index, the write flag, the clock select and the reload output are zero, and `rdata` reads as zero.
- R2: A write with `be[1]` set latches `wdata[15:10]` as the index and `wdata[9]` as the write flag. Lane 1 reads back as {index, flag, 0}.
- R3: A write with `be[2]` set, while the latched flag is one and the latched index is below NUM_REGS, stores `wdata[23:16]` into the indexed entry. The index and flag used are the values latched before that cycle.
- R4: A data-lane write while the latched flag is zero leaves the bank unchanged.
- R5: An index of NUM_REGS or above selects no entry. Data-lane writes are ignored and `rdata[23:16]` reads zero.
- R6: `rdata[23:16]` shows the indexed entry combinationally, in the same cycle the index changes.
- R7: A write with `be[0]` set loads `wdata[1:0]` into the clock select, shown on `clk_sel_o` and read back on `rdata[1:0]`. All other bits of lane 0 read zero.
- R8: A lane-0 write with `wdata[6]` set raises `reload_o` for exactly the one cycle after the write. Without bit 6, no pulse is produced.
- R9: Entry k of the bank appears on `bank_o[8k+7:8k]` at all times.
- R10: Lanes whose byte enable is clear are not changed by a write. Lane 3 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| be | input | 4 | Byte enables for the control word |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Control word read-back |
| clk_sel_o | output | 2 | Active pixel-clock select |
| reload_o | output | 1 | One-cycle clock reload request |
| bank_o | output | NUM_REGS*8 | All bank entries, flattened |

## Verification
The bench builds the block with its defaults: 32 entries of eight bits. With these values the index field reaches 64 codes, so a full sweep covers every in-range entry and every out-of-range code. Every select value is exercised with and without the reload bit. The sweep is repeated with the write flag cleared. A combined index-and-data write checks that the data lane uses the index latched before that cycle.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;
  localparam int LANE_W      = 8;
  localparam int NUM_LANES   = 4;
  localparam int IDX_FIELD_W = 6;
  localparam int SEL_W       = 2;
  localparam int LANE_CTRL   = 0;
  localparam int LANE_IDX    = 1;
  localparam int LANE_DATA   = 2;
  localparam int RELOAD_BIT  = 6;
  localparam int WFLAG_BIT   = 1;
  localparam int IDX_LSB     = 2;

  typedef logic [IDX_FIELD_W-1:0] idx_field_t;
  typedef logic [LANE_W-1:0]      lane_t;
endpackage

// File: rtl/clkreg_ctrl.sv
module clkreg_ctrl
  import clkreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  lane_t            ctrl_byte,
  output logic [SEL_W-1:0] sel_q,
  output logic             reload_q
);
  logic [SEL_W-1:0] sel_d;
  logic             reload_d;

  always_comb begin
    sel_d    = sel_q;
    reload_d = 1'b0;
    if (wr_ctrl) begin
      sel_d    = ctrl_byte[SEL_W-1:0];
      reload_d = ctrl_byte[RELOAD_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      reload_q <= 1'b0;
    end else begin
      sel_q    <= sel_d;
      reload_q <= reload_d;
    end
  end
endmodule

// File: rtl/clkreg_index.sv
module clkreg_index
  import clkreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_idx,
  input  lane_t      idx_byte,
  output idx_field_t idx_q,
  output logic       wflag_q
);
  idx_field_t idx_d;
  logic       wflag_d;

  always_comb begin
    idx_d   = idx_q;
    wflag_d = wflag_q;
    if (wr_idx) begin
      idx_d   = idx_byte[LANE_W-1:IDX_LSB];
      wflag_d = idx_byte[WFLAG_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      wflag_q <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      wflag_q <= wflag_d;
    end
  end
endmodule

// File: rtl/clkreg_bank.sv
module clkreg_bank
  import clkreg_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_data,
  input  idx_field_t                idx,
  input  logic                      wflag,
  input  logic [REG_W-1:0]          wbyte,
  output logic [NUM_REGS*REG_W-1:0] bank_flat,
  output logic [REG_W-1:0]          rd_byte
);
  logic [REG_W-1:0] entry_q [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_entry
    logic             hit;
    logic             en;
    logic [REG_W-1:0] entry_d;

    assign hit = (idx == IDX_FIELD_W'(k));
    assign en  = wr_data && wflag && hit;

    always_comb begin
      entry_d = entry_q[k];
      if (en) entry_d = wbyte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) entry_q[k] <= '0;
      else        entry_q[k] <= entry_d;
    end

    assign bank_flat[k*REG_W +: REG_W] = entry_q[k];
  end

  always_comb begin
    rd_byte = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (idx == IDX_FIELD_W'(k)) rd_byte = entry_q[k];
    end
  end
endmodule

// File: rtl/clkreg_port.sv
module clkreg_port
  import clkreg_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [NUM_LANES-1:0]      be,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output logic [SEL_W-1:0]          clk_sel_o,
  output logic                      reload_o,
  output logic [NUM_REGS*REG_W-1:0] bank_o
);
  lane_t            lane_w [NUM_LANES];
  logic             wr_lane [NUM_LANES];
  idx_field_t       idx_q;
  logic             wflag_q;
  logic [REG_W-1:0] rd_byte;
  lane_t            data_lane;
  lane_t            ctrl_lane;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign lane_w[l]  = wdata[l*LANE_W +: LANE_W];
    assign wr_lane[l] = wr_en && be[l];
  end

  clkreg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_lane[LANE_CTRL]),
    .ctrl_byte (lane_w[LANE_CTRL]),
    .sel_q     (clk_sel_o),
    .reload_q  (reload_o)
  );

  clkreg_index u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_idx   (wr_lane[LANE_IDX]),
    .idx_byte (lane_w[LANE_IDX]),
    .idx_q    (idx_q),
    .wflag_q  (wflag_q)
  );

  clkreg_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_data   (wr_lane[LANE_DATA]),
    .idx       (idx_q),
    .wflag     (wflag_q),
    .wbyte     (lane_w[LANE_DATA][REG_W-1:0]),
    .bank_flat (bank_o),
    .rd_byte   (rd_byte)
  );

  always_comb begin
    data_lane = '0;
    data_lane[REG_W-1:0] = rd_byte;
    ctrl_lane = '0;
    ctrl_lane[SEL_W-1:0] = clk_sel_o;
  end

  assign rdata = {8'h00, data_lane, idx_q, wflag_q, 1'b0, ctrl_lane};
endmodule

// File: rtl/clkreg_port_chk.sv
module clkreg_port_chk #(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [3:0]                be,
  input logic [31:0]               wdata,
  input logic [31:0]               rdata,
  input logic [1:0]                clk_sel_o,
  input logic                      reload_o,
  input logic [NUM_REGS*REG_W-1:0] bank_o
);
  AST_RELOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    reload_o |-> $past(wr_en && be[0] && wdata[6])) else $error("reload"); // R8
  AST_RELOAD_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && be[0] && wdata[6]) |=> reload_o) else $error("reload fire"); // R8
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && be[0]) |=> $stable(clk_sel_o)) else $error("sel"); // R7
  AST_BANK_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && be[2]) |=> $stable(bank_o)) else $error("bank nowr"); // R10
  AST_BANK_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && be[2] && !rdata[9]) |=> $stable(bank_o)) else $error("bank flag"); // R4
  AST_OOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rdata[15:10]) >= NUM_REGS) |-> (rdata[23:16] == 8'h00)) else $error("oor"); // R5
  AST_READ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rdata[15:10]) < NUM_REGS) |->
      (rdata[16 +: REG_W] == bank_o[rdata[15:10]*REG_W +: REG_W])) else $error("rd"); // R6
endmodule

bind clkreg_port clkreg_port_chk #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_chk (.*);

// File: tb/clkreg_port_tb_top.sv
module clkreg_port_tb_top;
  localparam int NR = 32;
  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [3:0] be;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [1:0] clk_sel_o;
  logic reload_o;
  logic [NR*8-1:0] bank_o;
  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;
  logic [7:0] expb [NR];

  always #10 clk = ~clk;

  clkreg_port dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .be(be), .wdata(wdata),
    .rdata(rdata), .clk_sel_o(clk_sel_o), .reload_o(reload_o), .bank_o(bank_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; be = b; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; be = 4'h0; wdata = 32'h0;
  endtask

  task automatic check_bank(input string req);
    for (int k = 0; k < NR; k++) check(req, {24'h0, bank_o[k*8 +: 8]}, {24'h0, expb[k]});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; be = 4'h0; wdata = 32'h0;
    for (int k = 0; k < NR; k++) expb[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", rdata, 32'h0);
    check("R1 sel", {30'h0, clk_sel_o}, 32'h0);
    check("R1 reload", {31'h0, reload_o}, 32'h0);
    check_bank("R1 bank");

    // R2 R3 R5 R6: sweep all 64 index codes with write flag set
    for (int i = 0; i < 64; i++) begin
      logic [7:0] d;
      d = 8'((i * 37 + 5) & 255);
      wr(4'b0010, {16'h0, 6'(i), 2'b10, 8'h00});
      check("R2 idx lane", {24'h0, rdata[15:8]}, {24'h0, 6'(i), 2'b10});
      wr(4'b0100, {8'h00, d, 16'h0});
      if (i < NR) expb[i] = d;
      check(i < NR ? "R3 R6 data lane" : "R5 out of range read",
            {24'h0, rdata[23:16]}, {24'h0, (i < NR) ? d : 8'h00});
    end
    check_bank("R9 bank after sweep");

    // R4: flag cleared, writes ignored
    for (int i = 0; i < NR; i++) begin
      wr(4'b0010, {16'h0, 6'(i), 2'b00, 8'h00});
      check("R2 flag clear", {24'h0, rdata[15:8]}, {24'h0, 6'(i), 2'b00});
      wr(4'b0100, {8'h00, ~expb[i], 16'h0});
      check("R4 ignored write", {24'h0, rdata[23:16]}, {24'h0, expb[i]});
    end
    check_bank("R4 bank unchanged");

    // R7 R8: every select, with and without reload bit
    for (int v = 0; v < 8; v++) begin
      logic rb;
      rb = v[2];
      wr(4'b0001, {24'h0, 1'b1, rb, 4'b1111, 2'(v)});
      check("R7 sel out", {30'h0, clk_sel_o}, {30'h0, 2'(v)});
      check("R7 ctrl lane", {24'h0, rdata[7:0]}, {30'h0, 2'(v)});
      check("R8 reload pulse", {31'h0, reload_o}, {31'h0, rb});
      @(negedge clk);
      check("R8 reload single", {31'h0, reload_o}, 32'h0);
    end

    // R10: no enables, lane 3 writes
    wr(4'b0000, 32'hFFFF_FFFF);
    check("R10 no enable", {26'h0, rdata[15:10]}, {26'h0, 6'(NR - 1)});
    check("R10 sel held", {30'h0, clk_sel_o}, 32'h3);
    check_bank("R10 bank held");
    wr(4'b1000, 32'hFFFF_FFFF);
    check("R10 lane3 zero", {24'h0, rdata[31:24]}, 32'h0);

    // R3: combined lane1+lane2 write uses previously latched index
    wr(4'b0010, {16'h0, 6'd3, 2'b10, 8'h00});
    wr(4'b0110, {8'h00, 8'hAA, 6'd4, 2'b10, 8'h00});
    expb[3] = 8'hAA;
    check("R3 old index used", {24'h0, bank_o[3*8 +: 8]}, 32'hAA);
    check("R6 new index read", {24'h0, rdata[23:16]}, {24'h0, expb[4]});
    check_bank("R9 final bank");

    // R1: reset again clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < NR; k++) expb[k] = 8'h00;
    @(negedge clk);
    check("R1 rdata after reset", rdata, 32'h0);
    check_bank("R1 bank after reset");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule